// File: doc/BRIEF.md
# PHY Test Register Bridge

This block models the PHY end of a software-driven test-register port. A host writes a 32-bit control word into a plain register, and the word reaches this block on `ctrl_word`. Inside the word sit a data byte, a register address, a port index, a write-enable bit, an active-low test reset bit and a test-clock bit. The test clock is not a real clock. The block samples it on the system clock and commits the data byte into a small per-port register file when it sees that bit go from 0 to 1. Because of this, the host's usual write takes three word updates: the fields with the clock bit low, then the same fields with it high, then low again.

The parameter `LAYOUT` picks one of two bit placements for the fields, and the size of the register file follows from it. The whole file is available on a flat output bus. One bit of one register also drives a PHY clock-enable output.

Top module: `phytst_bridge`

## Requirements
- R1: In layout 0 the word carries write data in bits 7:0, the address in bits 15:8, the port index in bits 18:16, write-enable in bit 21, the test clock in bit 22 and the active-low test reset in bit 23. A commit stores the data byte at entry [port][address] of a 2-port by 256-entry file. The entry appears on `file_flat[((port*DEPTH)+address)*8 +: 8]` one system clock after the sampled rising edge.
- R2: In layout 1 the address is bits 11:8, the port is bit 12, write-enable is bit 13, the test clock is bit 14 and the active-low test reset is bit 15. The data byte is still bits 7:0, and the file is 2 ports by 16 entries.
- R3: A commit happens only in a system clock cycle where the test-clock bit is 1 and its value from the previous cycle was 0. Holding the bit high while the other fields change writes nothing more.
- R4: When write-enable is 0, a test-clock rising edge leaves the file unchanged.
- R5: While the test reset bit is 0, every file entry clears to zero on the next system clock, and writes are ignored.
- R6: In layout 0, a port index greater than 1 writes no entry of either port.
- R7: `phy_clk_en` equals bit 2 of register 0x06 of port 0.
- R8: After the system reset `rst_n` is released, all file entries and `phy_clk_en` read 0, and the stored previous test-clock value is 0.
- R9: The three-word host sequence (clock low, high, low, with the other fields held the same) commits exactly one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ctrl_word | input | 32 | Control word from the host register |
| file_flat | output | NUM_PORTS*DEPTH*8 | Register file contents, entry [p][a] at bits ((p*DEPTH)+a)*8 +: 8 |
| phy_clk_en | output | 1 | PHY clock enable, taken from the register file |

## Verification
The checks that run on every cycle cover the following: a detected edge never lasts two cycles, the file holds still when write-enable is low or the port index is out of range, a low test reset leaves the file at zero, and the clock enable turns on only after a matching commit. Some behaviour can only be shown by the bench's scenarios. Those are that the right byte lands at the right port and address in each layout, that a held-high clock bit with changing data writes nothing more, and that writes work again once the test reset returns high. The bench's reference model checks the whole file against its own copy after every clock.

// File: rtl/phytst_pkg.sv
package phytst_pkg;

   typedef struct packed {
      logic [7:0] data;
      logic [7:0] addr;
      logic [2:0] port;
      logic       wren;
      logic       tclk;
      logic       trst_n;
   } tfields_t;

   function automatic int addr_width(input int layout);
      return (layout == 0) ? 8 : 4;
   endfunction

   function automatic int port_width(input int layout);
      return (layout == 0) ? 3 : 1;
   endfunction

endpackage

// File: rtl/phytst_decode.sv
module phytst_decode
   import phytst_pkg::*;
#(
   parameter int LAYOUT = 0
) (
   input  logic [31:0] word,
   output tfields_t    fields
);

   generate
      if (LAYOUT == 0) begin : g_lay0
         logic unused_word;
         assign unused_word   = ^{word[31:24], word[20:19]};
         assign fields.data   = word[7:0];
         assign fields.addr   = word[15:8];
         assign fields.port   = word[18:16];
         assign fields.wren   = word[21];
         assign fields.tclk   = word[22];
         assign fields.trst_n = word[23];
      end else begin : g_lay1
         logic unused_word;
         assign unused_word   = ^word[31:16];
         assign fields.data   = word[7:0];
         assign fields.addr   = {4'b0000, word[11:8]};
         assign fields.port   = {2'b00, word[12]};
         assign fields.wren   = word[13];
         assign fields.tclk   = word[14];
         assign fields.trst_n = word[15];
      end
   endgenerate

endmodule

// File: rtl/phytst_edge.sv
module phytst_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic tclk,
   output logic rise,
   output logic prev_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= tclk;
   end

   assign rise = tclk & ~prev_q;

   // R3: an edge is a single-cycle event
   a_r3_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

   // R3: after an edge the stored previous value is high
   a_r3_prev_high: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> prev_q);

endmodule

// File: rtl/phytst_regfile.sv
module phytst_regfile #(
   parameter int NUM_PORTS = 2,
   parameter int DEPTH     = 256,
   parameter int AW        = 8,
   parameter int PW        = 3,
   parameter int DW        = 8,
   localparam int FILE_W   = NUM_PORTS * DEPTH * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [PW-1:0]     wport,
   input  logic [AW-1:0]     waddr,
   input  logic [DW-1:0]     wdata,
   output logic [FILE_W-1:0] flat
);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("regfile depth must equal 2**AW");
      end
   endgenerate

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [DW-1:0] mem [DEPTH];
      logic          sel;

      assign sel = we && (int'(wport) == p);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (sel) begin
            mem[waddr] <= wdata;
         end
      end

      for (genvar a = 0; a < DEPTH; a++) begin : g_ent
         assign flat[((p * DEPTH) + a) * DW +: DW] = mem[a];
      end
   end

   // R5: a clear request empties the whole file
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flat == '0));

endmodule

// File: rtl/phytst_bridge.sv
module phytst_bridge
   import phytst_pkg::*;
#(
   parameter  int LAYOUT    = 0,
   parameter  int NUM_PORTS = 2,
   parameter  int CLK_REG   = 6,
   parameter  int CLK_BIT   = 2,
   localparam int AW        = addr_width(LAYOUT),
   localparam int PW        = port_width(LAYOUT),
   localparam int DEPTH     = 1 << AW,
   localparam int DW        = 8,
   localparam int FILE_W    = NUM_PORTS * DEPTH * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ctrl_word,
   output logic [FILE_W-1:0] file_flat,
   output logic              phy_clk_en
);

   generate
      if (LAYOUT != 0 && LAYOUT != 1) begin : g_bad_layout
         $error("LAYOUT must be 0 or 1");
      end
      if (NUM_PORTS < 1 || NUM_PORTS > (1 << PW)) begin : g_bad_ports
         $error("NUM_PORTS out of range for the port field");
      end
      if (CLK_REG >= DEPTH || CLK_BIT >= DW) begin : g_bad_clkbit
         $error("clock-enable location outside the file");
      end
   endgenerate

   tfields_t f;
   logic     rise;
   logic     prev_q;
   logic     in_range;
   logic     commit;
   logic     clr;
   logic     unused_fields;

   phytst_decode #(.LAYOUT(LAYOUT)) u_decode (
      .word   (ctrl_word),
      .fields (f)
   );

   phytst_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .tclk   (f.tclk),
      .rise   (rise),
      .prev_q (prev_q)
   );

   assign in_range      = int'(f.port) < NUM_PORTS;
   assign commit        = rise & f.wren & f.trst_n & in_range;
   assign clr           = ~f.trst_n;
   assign unused_fields = ^{f.addr, f.port, prev_q};

   phytst_regfile #(
      .NUM_PORTS (NUM_PORTS),
      .DEPTH     (DEPTH),
      .AW        (AW),
      .PW        (PW),
      .DW        (DW)
   ) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .we    (commit),
      .wport (f.port[PW-1:0]),
      .waddr (f.addr[AW-1:0]),
      .wdata (f.data),
      .flat  (file_flat)
   );

   assign phy_clk_en = file_flat[CLK_REG * DW + CLK_BIT];

   // R4: no write-enable, no change while test reset is high
   a_r4_no_wren_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!f.wren && f.trst_n) |=> $stable(file_flat));

   // R6: out-of-range port leaves the file alone
   a_r6_bad_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (f.trst_n && !in_range) |=> $stable(file_flat));

   // R5: test reset low means an empty file next cycle
   a_r5_trst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !f.trst_n |=> (file_flat == '0));

   // R7: clock enable rises only after a commit with bit set to that entry
   a_r7_clk_en_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_clk_en) |-> $past(commit && f.port == 3'd0
                                  && int'(f.addr) == CLK_REG && f.data[CLK_BIT]));

   // R3: no commit without a fresh edge of the test clock
   a_r3_commit_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (f.tclk && $past(f.tclk)) |=> $stable(file_flat) || $past(clr));

endmodule

// File: tb/test_phytst_bridge.sv
module test_phytst_bridge;

   localparam int D0 = 256;
   localparam int D1 = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] w0 = '0;
   logic [31:0] w1 = '0;
   logic [2*D0*8-1:0] flat0;
   logic [2*D1*8-1:0] flat1;
   logic en0, en1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   phytst_bridge #(.LAYOUT(0)) i_phytst_bridge (
      .clk(clk), .rst_n(rst_n), .ctrl_word(w0), .file_flat(flat0), .phy_clk_en(en0));

   phytst_bridge #(.LAYOUT(1)) i_phytst_bridge_l1 (
      .clk(clk), .rst_n(rst_n), .ctrl_word(w1), .file_flat(flat1), .phy_clk_en(en1));

   // behavioural reference model
   bit [7:0] m0 [2][D0];
   bit [7:0] m1 [2][D1];
   bit pv0, pv1;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m0[p, a]) m0[p][a] = 0;
         foreach (m1[p, a]) m1[p][a] = 0;
         pv0 = 0; pv1 = 0;
      end else begin
         if (!w0[23]) foreach (m0[p, a]) m0[p][a] = 0;
         else if (w0[22] && !pv0 && w0[21] && w0[18:16] <= 1)
            m0[w0[16]][w0[15:8]] = w0[7:0];
         pv0 = w0[22];
         if (!w1[15]) foreach (m1[p, a]) m1[p][a] = 0;
         else if (w1[14] && !pv1 && w1[13])
            m1[w1[12]][w1[11:8]] = w1[7:0];
         pv1 = w1[14];
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // whole-file comparison on every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int bad0 = -1;
         int bad1 = -1;
         for (int i = 0; i < 2 * D0; i++)
            if (flat0[i*8 +: 8] !== m0[i / D0][i % D0] && bad0 < 0) bad0 = i;
         for (int i = 0; i < 2 * D1; i++)
            if (flat1[i*8 +: 8] !== m1[i / D1][i % D1] && bad1 < 0) bad1 = i;
         chk("R1 model", (bad0 < 0) ? 0 : flat0[bad0*8 +: 8],
             (bad0 < 0) ? 0 : m0[bad0 / D0][bad0 % D0]);
         chk("R2 model", (bad1 < 0) ? 0 : flat1[bad1*8 +: 8],
             (bad1 < 0) ? 0 : m1[bad1 / D1][bad1 % D1]);
      end
   end

   function automatic logic [31:0] mk0(bit rs, bit ck, bit we, bit [2:0] pt,
                                       bit [7:0] ad, bit [7:0] dt);
      return {8'h00, rs, ck, we, 2'b00, pt, ad, dt};
   endfunction

   function automatic logic [31:0] mk1(bit rs, bit ck, bit we, bit pt,
                                       bit [3:0] ad, bit [7:0] dt);
      return {16'h0000, rs, ck, we, pt, ad, dt};
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr0(bit we, bit [2:0] pt, bit [7:0] ad, bit [7:0] dt);
      w0 = mk0(1, 0, we, pt, ad, dt); step();
      w0 = mk0(1, 1, we, pt, ad, dt); step();
      w0 = mk0(1, 0, we, pt, ad, dt); step();
   endtask

   task automatic wr1(bit pt, bit [3:0] ad, bit [7:0] dt);
      w1 = mk1(1, 0, 1, pt, ad, dt); step();
      w1 = mk1(1, 1, 1, pt, ad, dt); step();
      w1 = mk1(1, 0, 1, pt, ad, dt); step();
   endtask

   function automatic int e0(int p, int a);
      return flat0[((p * D0) + a) * 8 +: 8];
   endfunction

   function automatic int e1(int p, int a);
      return flat1[((p * D1) + a) * 8 +: 8];
   endfunction

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      w0 = mk0(1, 0, 0, 0, 0, 0);
      w1 = mk1(1, 0, 0, 0, 0, 0);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      @(negedge clk);
      chk("R8 file0 zero", (flat0 == '0) ? 1 : 0, 1);
      chk("R8 file1 zero", (flat1 == '0) ? 1 : 0, 1);
      chk("R8 clk_en", en0, 0);

      // R7, R9: enable PHY clock through port 0 register 0x06
      step();
      wr0(1, 0, 8'h06, 8'h04);
      @(negedge clk);
      chk("R9 single commit", e0(0, 6), 8'h04);
      chk("R7 clk_en on", en0, 1);

      // R1: port 1 high address
      step();
      wr0(1, 1, 8'hA5, 8'h3C);
      @(negedge clk);
      chk("R1 port1 addr a5", e0(1, 8'hA5), 8'h3C);
      chk("R1 port0 addr a5 untouched", e0(0, 8'hA5), 0);

      // R3: clock held high while data changes
      step();
      w0 = mk0(1, 0, 1, 0, 8'h10, 8'h11); step();
      w0 = mk0(1, 1, 1, 0, 8'h10, 8'h11); step();
      w0 = mk0(1, 1, 1, 0, 8'h10, 8'h22); step(); step(); step();
      @(negedge clk);
      chk("R3 held clock no rewrite", e0(0, 8'h10), 8'h11);
      step();
      w0 = mk0(1, 0, 1, 0, 8'h10, 8'h22); step();
      @(negedge clk);
      chk("R3 falling edge no write", e0(0, 8'h10), 8'h11);

      // R4: write-enable low
      step();
      wr0(0, 0, 8'h20, 8'h77);
      @(negedge clk);
      chk("R4 wren low", e0(0, 8'h20), 0);

      // R6: port index 5
      step();
      wr0(1, 5, 8'h30, 8'h99);
      @(negedge clk);
      chk("R6 port0 untouched", e0(0, 8'h30), 0);
      chk("R6 port1 untouched", e0(1, 8'h30), 0);

      // R5: test reset low clears and blocks writes
      step();
      w0 = mk0(0, 0, 1, 1, 8'h40, 8'h55); step();
      w0 = mk0(0, 1, 1, 1, 8'h40, 8'h55); step();
      @(negedge clk);
      chk("R5 cleared", (flat0 == '0) ? 1 : 0, 1);
      chk("R5 write ignored", e0(1, 8'h40), 0);
      chk("R7 clk_en cleared", en0, 0);
      step();
      w0 = mk0(1, 0, 1, 1, 8'h40, 8'h55); step();
      wr0(1, 1, 8'h40, 8'h66);
      @(negedge clk);
      chk("R5 write after release", e0(1, 8'h40), 8'h66);

      // R2: layout 1 fields
      step();
      wr1(1, 4'hF, 8'h5A);
      wr1(0, 4'h6, 8'h04);
      @(negedge clk);
      chk("R2 port1 addr f", e1(1, 15), 8'h5A);
      chk("R2 port0 addr f untouched", e1(0, 15), 0);
      chk("R7 layout1 clk_en", en1, 1);

      step(); step();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule